// File: doc/BRIEF.md
# Single-Precision Packer

This block turns an unpacked floating-point value into a 32-bit IEEE-754 single-precision word. It takes four inputs: a 32-bit mantissa whose leading one is explicit at bit 31, a signed unbiased exponent, a sticky carry bit and a sign source word. The block does not normalise the mantissa. Whatever sits in bits 30..8 becomes the fraction, and bits 8..0 together with the sticky carry decide the rounding.

The block first decides which special case applies. The candidates are NaN passthrough, overflow to infinity, underflow to zero and an all-zero mantissa. Checking follows that fixed order, and the first match wins. When none of them matches, the biased exponent and the fraction are joined into one 31-bit field and the round-up bit is added to it. A carry out of the fraction therefore moves into the exponent. A parameter selects whether the packed word goes through an output register, which adds one cycle, or leaves the block combinationally.

Top module: `fpk_packer`

## Requirements
- R1: The round-up bit is set exactly when mantissa bit 7 is 1 and at least one of these holds: mantissa bit 8 is 1, any of mantissa bits 6..0 is 1, or the carry input is 1. An exact tie (bit 7 = 1, lower bits 0, carry 0) rounds up only when bit 8 is 1.
- R2: If mantissa bit 31 is 0 and the exponent equals 255, result bits 30..23 are 0xFF and bits 22..0 are mantissa bits 30..8. No rounding is applied in this case.
- R3: If mantissa bit 31 is 1 and the exponent is 127 or more, result bits 30..0 are 0x7F800000 (infinity).
- R4: If mantissa bit 31 is 1 and the exponent is -128 or less, result bits 30..0 are zero.
- R5: An all-zero mantissa gives zero in result bits 30..0.
- R6: In every other case the biased exponent is (exponent + 128) mod 256 when mantissa bit 31 is 1, and 0 when it is 0. Result bits 30..0 equal {biased exponent, mantissa bits 30..8} plus the round-up bit, so a fraction carry increments the exponent field.
- R7: The cases of R2, R3, R4, R5 and R6 are tested in that order and the first match decides. For example, a zero mantissa with exponent 255 yields 0x7F800000 through R2.
- R8: Result bit 31 is bit 31 of the sign source word. Sign word bits 30..0 have no effect on the result.
- R9: With REG_OUT = 1 the result appears on the clock edge after the inputs are presented, and it reads zero while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low synchronous reset of the output register |
| mant_i | input | 32 | Mantissa, explicit leading one at bit 31 |
| exp_i | input | EXP_IN_W | Signed unbiased exponent |
| carry_i | input | 1 | Sticky carry from earlier arithmetic, joins the round decision |
| sign_i | input | 32 | Sign source word, only bit 31 is used |
| res_o | output | 32 | Packed single-precision word |

## Verification
The checker assumes the inputs are stable across each clock edge. This lets it relate the classifier's case, the round decision and the assembled word within one cycle, and compare the registered output with the previous cycle's combinational word. The bench drives inputs only on falling edges and reads results one full cycle later, which meets that assumption. Random exponents are drawn from a window that spans both thresholds and the NaN code. Random mantissas sometimes have bit 31 cleared, so every case of R7 is reached, and the directed vectors add the rounding ties and fraction-carry cases.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  localparam int MANT_W  = 32;
  localparam int FRAC_W  = 23;
  localparam int BEXP_W  = 8;
  localparam int WORD_W  = 1 + BEXP_W + FRAC_W;
  localparam int FIELD_W = WORD_W - 1;
  localparam int GUARD   = MANT_W - 1 - FRAC_W;  // index of the half-ulp bit + 1

  typedef enum logic [2:0] {
    CL_NAN   = 3'd0,
    CL_INF   = 3'd1,
    CL_UFLOW = 3'd2,
    CL_ZERO  = 3'd3,
    CL_NORM  = 3'd4
  } cls_e;

  // half-ulp bit set and something beyond a pure tie (odd lsb, lower bits, sticky)
  function automatic logic round_up(input logic [MANT_W-1:0] m, input logic c);
    return m[GUARD-1] & (m[GUARD] | (|m[GUARD-2:0]) | c);
  endfunction

  // exponent and fraction joined so the increment may ripple into the exponent
  function automatic logic [FIELD_W-1:0] join_field(input logic [BEXP_W-1:0] bexp,
                                                    input logic [FRAC_W-1:0] frac,
                                                    input logic              up);
    return {bexp, frac} + FIELD_W'(up);
  endfunction
endpackage

// File: rtl/fpk_round.sv
module fpk_round
  import fpk_pkg::*;
(
  input  logic [MANT_W-1:0] mant_i,
  input  logic              carry_i,
  output logic              up_o
);
  always_comb up_o = round_up(mant_i, carry_i);
endmodule

// File: rtl/fpk_classify.sv
module fpk_classify
  import fpk_pkg::*;
#(
  parameter int EXP_IN_W = 32
) (
  input  logic        [MANT_W-1:0]   mant_i,
  input  logic signed [EXP_IN_W-1:0] exp_i,
  output cls_e                       cls_o
);
  localparam int NAN_CODE = (1 << BEXP_W) - 1;
  localparam int INF_MIN  = (1 << (BEXP_W - 1)) - 1;
  localparam int UF_MAX   = -(1 << (BEXP_W - 1));
  localparam logic signed [EXP_IN_W-1:0] NAN_CODE_S = NAN_CODE;
  localparam logic signed [EXP_IN_W-1:0] INF_MIN_S  = INF_MIN;
  localparam logic signed [EXP_IN_W-1:0] UF_MAX_S   = UF_MAX;

  logic lead;
  always_comb begin
    lead = mant_i[MANT_W-1];
    if (!lead && (exp_i == NAN_CODE_S))      cls_o = CL_NAN;
    else if (lead && (exp_i >= INF_MIN_S))   cls_o = CL_INF;
    else if (lead && (exp_i <= UF_MAX_S))    cls_o = CL_UFLOW;
    else if (mant_i == '0)                   cls_o = CL_ZERO;
    else                                     cls_o = CL_NORM;
  end
endmodule

// File: rtl/fpk_assemble.sv
module fpk_assemble
  import fpk_pkg::*;
#(
  parameter int EXP_IN_W = 32
) (
  input  cls_e                  cls_i,
  input  logic [MANT_W-1:0]     mant_i,
  input  logic [EXP_IN_W-1:0]   exp_i,
  input  logic                  up_i,
  input  logic                  sign_i,
  output logic [WORD_W-1:0]     word_o
);
  localparam logic [BEXP_W-1:0] BIAS_ADJ = BEXP_W'(1 << (BEXP_W - 1));
  localparam logic [BEXP_W-1:0] ALL_ONES = '1;

  logic [FRAC_W-1:0] frac;
  logic [BEXP_W-1:0] bexp;

  always_comb begin
    frac   = mant_i[MANT_W-2 -: FRAC_W];
    bexp   = mant_i[MANT_W-1] ? (exp_i[BEXP_W-1:0] + BIAS_ADJ) : '0;
    word_o = '0;
    word_o[WORD_W-1] = sign_i;
    unique case (cls_i)
      CL_NAN:  word_o[FIELD_W-1:0] = {ALL_ONES, frac};
      CL_INF:  word_o[FIELD_W-1:0] = {ALL_ONES, {FRAC_W{1'b0}}};
      CL_NORM: word_o[FIELD_W-1:0] = join_field(bexp, frac, up_i);
      default: word_o[FIELD_W-1:0] = '0;
    endcase
  end
endmodule

// File: rtl/fpk_packer.sv
module fpk_packer
  import fpk_pkg::*;
#(
  parameter int EXP_IN_W = 32,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [MANT_W-1:0]          mant_i,
  input  logic signed [EXP_IN_W-1:0] exp_i,
  input  logic                       carry_i,
  input  logic [WORD_W-1:0]          sign_i,
  output logic [WORD_W-1:0]          res_o
);
  cls_e              cls;
  logic              rnd_up;
  logic [WORD_W-1:0] res_c;

  fpk_round u_round (
    .mant_i (mant_i),
    .carry_i(carry_i),
    .up_o   (rnd_up)
  );

  fpk_classify #(.EXP_IN_W(EXP_IN_W)) u_cls (
    .mant_i(mant_i),
    .exp_i (exp_i),
    .cls_o (cls)
  );

  fpk_assemble #(.EXP_IN_W(EXP_IN_W)) u_asm (
    .cls_i (cls),
    .mant_i(mant_i),
    .exp_i (exp_i),
    .up_i  (rnd_up),
    .sign_i(sign_i[WORD_W-1]),
    .word_o(res_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [WORD_W-1:0] res_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_c;
      end
      assign res_o = res_q;
    end else begin : g_comb
      assign res_o = res_c;
    end
  endgenerate
endmodule

// File: rtl/fpk_packer_chk.sv
module fpk_packer_chk
  import fpk_pkg::*;
#(
  parameter int EXP_IN_W = 32,
  parameter bit REG_OUT  = 1'b1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [MANT_W-1:0]          mant_i,
  input logic signed [EXP_IN_W-1:0] exp_i,
  input logic [WORD_W-1:0]          sign_i,
  input cls_e                       cls,
  input logic                       rnd_up,
  input logic [WORD_W-1:0]          res_c,
  input logic [WORD_W-1:0]          res_o
);
  localparam logic signed [EXP_IN_W-1:0] NAN_E = (1 << BEXP_W) - 1;

  p_round_half_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_up |-> mant_i[GUARD-1]);

  p_nan_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CL_NAN) |-> (res_c[FIELD_W-1:FRAC_W] == '1 &&
                         res_c[FRAC_W-1:0] == mant_i[MANT_W-2 -: FRAC_W]));

  p_inf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CL_INF) |-> (res_c[FIELD_W-1:0] == {{BEXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  p_uflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CL_UFLOW) |-> (res_c[FIELD_W-1:0] == '0));

  p_zero_mant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CL_ZERO) |-> (res_c[FIELD_W-1:0] == '0));

  p_norm_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CL_NORM && !rnd_up) |-> (res_c[FRAC_W-1:0] == mant_i[MANT_W-2 -: FRAC_W]));

  p_nan_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mant_i[MANT_W-1] && exp_i == NAN_E) |-> (cls == CL_NAN));

  generate
    if (REG_OUT) begin : g_regchk
      p_sign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (res_o[WORD_W-1] == $past(sign_i[WORD_W-1])));
      p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (res_o == $past(res_c)));
    end
  endgenerate
endmodule

bind fpk_packer fpk_packer_chk #(.EXP_IN_W(EXP_IN_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .mant_i(mant_i),
  .exp_i (exp_i),
  .sign_i(sign_i),
  .cls   (cls),
  .rnd_up(rnd_up),
  .res_c (res_c),
  .res_o (res_o)
);

// File: tb/fpk_packer_test.sv
module fpk_packer_test;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [31:0]        mant = '0;
  logic signed [31:0] expn = '0;
  logic               carry = 1'b0;
  logic [31:0]        sign = '0;
  logic [31:0]        res;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpk_packer #(.EXP_IN_W(32), .REG_OUT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mant_i(mant), .exp_i(expn),
    .carry_i(carry), .sign_i(sign), .res_o(res)
  );

  // independent statement of the packing rules
  function automatic logic [31:0] model(logic [31:0] m, int e, bit c, logic [31:0] s);
    logic [31:0] r;
    longint v;
    int up;
    bit tie_plus;
    tie_plus = m[8] || ((m & 32'h7f) != 0) || c;
    up = (m[7] && tie_plus) ? 1 : 0;
    r = s & 32'h8000_0000;
    if (!m[31] && e == 255)
      r = r | 32'h7f80_0000 | ((m >> 8) & 32'h007f_ffff);
    else if (m[31] && e >= 127)
      r = r | 32'h7f80_0000;
    else if (m[31] && e <= -128)
      r = r;
    else if (m == 0)
      r = r;
    else begin
      v = m[31] ? longint'((e + 128) & 255) : 0;
      v = v * 64'd8388608 + longint'((m >> 8) & 32'h007f_ffff) + up;
      r = r | (32'(v) & 32'h7fff_ffff);
    end
    return r;
  endfunction

  task automatic check(input logic [31:0] m, input int e, input bit c,
                       input logic [31:0] s, input string req);
    logic [31:0] exp_w;
    @(negedge clk);
    mant = m; expn = e; carry = c; sign = s;
    exp_w = model(m, e, c, s);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (res !== exp_w) begin
      fails++;
      $display("FAIL %s: m=%h e=%0d c=%0d s=%h actual=%h expected=%h",
               req, m, e, c, s, res, exp_w);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mant = 32'h8000_0000; expn = 0; sign = 32'h8000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;   // R9 reset state
    if (res !== 32'h0) begin
      fails++;
      $display("FAIL R9 reset: actual=%h expected=%h", res, 32'h0);
    end
    rst_n = 1'b1;

    check(32'h8000_0080, 0, 1'b0, 32'h0, "R1 tie even lsb");
    if (res !== 32'h4000_0000) begin fails++; $display("FAIL R1 tie: actual=%h expected=%h", res, 32'h4000_0000); end
    checks++;
    check(32'h8000_0180, 0, 1'b0, 32'h0, "R1 tie odd lsb");
    if (res !== 32'h4000_0002) begin fails++; $display("FAIL R1 odd: actual=%h expected=%h", res, 32'h4000_0002); end
    checks++;
    check(32'h8000_0080, 0, 1'b1, 32'h0, "R1 sticky carry");
    check(32'h8000_00c0, 0, 1'b0, 32'h0, "R1 above half");
    check(32'hffff_ff80, 0, 1'b0, 32'h0, "R6 fraction roll");
    if (res !== 32'h4080_0000) begin fails++; $display("FAIL R6 roll: actual=%h expected=%h", res, 32'h4080_0000); end
    checks++;
    check(32'hffff_ff80, 126, 1'b0, 32'h0, "R6 roll into top");
    check(32'h4000_0100, 255, 1'b0, 32'h8000_0000, "R2 nan pass");
    if (res !== 32'hffc0_0001) begin fails++; $display("FAIL R2 nan: actual=%h expected=%h", res, 32'hffc0_0001); end
    checks++;
    check(32'h4000_01ff, 255, 1'b1, 32'h0, "R2 nan no round");
    check(32'h8000_0000, 127, 1'b0, 32'h0, "R3 inf limit");
    check(32'hffff_ffff, 4000, 1'b1, 32'h8000_0000, "R3 inf large");
    check(32'h8000_0000, -128, 1'b0, 32'h0, "R4 uflow limit");
    check(32'hc000_0000, -90000, 1'b0, 32'h8000_0000, "R4 uflow large");
    check(32'h8000_0000, -127, 1'b0, 32'h0, "R6 smallest normal");
    check(32'h0000_0000, 5, 1'b1, 32'h0, "R5 zero mant");
    check(32'h0000_0000, 255, 1'b0, 32'h0, "R7 zero mant with 255");
    check(32'h0012_3400, 3, 1'b0, 32'h0, "R6 no lead bit");
    check(32'h8000_0000, 300, 1'b0, 32'h0, "R7 inf before zero");
    check(32'h4000_0000, 12, 1'b0, 32'h7fff_ffff, "R8 low sign bits ignored");
    check(32'h4000_0000, 12, 1'b0, 32'h8000_0000, "R8 sign copied");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] m;
      int e;
      m = $urandom();
      if ($urandom_range(0, 3) == 0) m[31] = 1'b0;
      if ($urandom_range(0, 15) == 0) m = '0;
      e = int'($urandom_range(0, 420)) - 145;
      if ($urandom_range(0, 9) == 0) e = 255;
      check(m, e, 1'($urandom_range(0, 1)), $urandom(), "R6 random R7 R8");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule